// File: doc/BRIEF.md
# Network controller command and status register file

This block is the host-visible register bank of a network controller. It holds 64 sixteen-bit registers behind a single word-wide port with separate write and read strobes. The bank decodes the command register and turns each accepted command into a one-cycle pulse for the transmit, receive, timer, resource-read and address-table-load engines. Those engines report completion and status through set pulses. The set pulses feed a status register that the host clears by writing ones. A mask register gates the status bits onto one level interrupt line.

Each register applies its own write rule. Some keep only a field. Two configuration registers accept writes only while the controller is held in software reset. A group of pointer registers drops bit 0. A group of tally registers stores the inverse of what is written. The command register never takes a written value as it stands. It ORs in accepted bits, lets paired start and stop commands cancel each other, and treats a write without the reset bit as a pure release of reset.

Top module: `netctl_regs`

## Requirements
- R1: After synchronous reset the command register (address 0) reads 0x0094 (reset, timer-stopped and receiver-off bits set). Status (1), mask (2), transmit control (3), receive control (4), configuration (5) and second configuration (6) read 0. The end-of-buffer count (7) reads 0x02F8, and irq is 0.
- R2: irq equals the OR of (mask AND status). It follows any change of either register at the same clock edge.
- R3: A host write to status (address 1) clears exactly the bits written as 1. Bits written as 0 keep their value.
- R4: Each bit of evt_set that is high for a cycle sets the matching status bit. When a host clear and a set of the same bit fall in the same cycle, the bit ends up set.
- R5: Writes keep only these fields: mask keeps bits 14:0, transmit control keeps bits 15:12, and receive control keeps bits 15:5. The other bits read 0.
- R6: Configuration takes a write masked to 0xBFFF, and second configuration takes a write masked to 0xF017. Each takes the write only while command bit 7 (reset) is set; otherwise the write has no effect.
- R7: Command bits are: 0 halt transmit, 1 transmit, 2 receiver off, 3 receiver on, 4 timer stop, 5 timer start, 7 software reset, 8 resource read, 9 table load. A command write ORs (data AND 0x03BF) into the register. On the next cycle, cmd_pulse carries the accepted bits for exactly one cycle. Bits outside 0x03BF never set.
- R8: While bit 7 is set, a command write with bit 7 clear only clears bit 7. No other bit changes and cmd_pulse stays 0.
- R9: After the OR, a written receiver-on bit clears receiver-off and a written receiver-off bit clears receiver-on. Timer start clears timer stop, and timer stop clears timer start. When both bits of a pair are written, both end up clear.
- R10: A command write with bit 7 set clears bits 0, 1, 8 and 9, including any written in the same write, after the R9 step. It then sets bits 7 and 2. cmd_pulse omits bits 0, 1, 8 and 9 for that write.
- R11: Addresses 8 to 11 store the written value with bit 0 cleared. Addresses 12 to 14 store the bitwise inverse of the written value. Address 7 and addresses 15 to 63 store the value unchanged.
- R12: rdata shows the addressed register one cycle after rd_en, with the value from before any write in that same cycle. rdata holds its value while rd_en is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe |
| rd_en | input | 1 | Host read strobe |
| addr | input | 6 | Register word address |
| wdata | input | 16 | Host write data |
| evt_set | input | 16 | Per-bit status set pulses from the engines |
| rdata | output | 16 | Registered read data |
| irq | output | 1 | Level interrupt, registered |
| cmd_pulse | output | 16 | One-cycle pulses of accepted command bits |

## Verification
The hardest case to reach is a host clear that lands on the very cycle an engine raises the same status bit. A queued write cannot arrange that coincidence; the stimulus drives evt_set and the status write together in one cycle, then reads the bit back. The command register's order-dependent cases need a set of writes that walk the register through release from reset, paired cancellation and a soft reset carrying suppressed bits. Every cycle compares rdata, irq and cmd_pulse against a behavioural model, so a wrong intermediate state shows up at once.

// File: rtl/netctl_pkg.sv
package netctl_pkg;
  localparam int DW        = 16;
  localparam int REG_COUNT = 64;

  // register addresses
  localparam int A_CMD  = 0;
  localparam int A_STAT = 1;
  localparam int A_MASK = 2;
  localparam int A_TXC  = 3;
  localparam int A_RXC  = 4;
  localparam int A_CFG  = 5;
  localparam int A_CFG2 = 6;
  localparam int A_EOB  = 7;
  localparam int GEN_BASE = 8;
  localparam int PTR_BASE = 8;
  localparam int PTR_CNT  = 4;
  localparam int TAL_BASE = 12;
  localparam int TAL_CNT  = 3;

  // command bit positions
  localparam int CB_HALT   = 0;
  localparam int CB_SEND   = 1;
  localparam int CB_RXOFF  = 2;
  localparam int CB_RXON   = 3;
  localparam int CB_TSTOP  = 4;
  localparam int CB_TSTART = 5;
  localparam int CB_SRST   = 7;
  localparam int CB_RSRC   = 8;
  localparam int CB_CAM    = 9;

  localparam int NPAIR = 2;
  localparam int PAIR_A [NPAIR] = '{CB_RXOFF, CB_TSTOP};
  localparam int PAIR_B [NPAIR] = '{CB_RXON,  CB_TSTART};

  localparam logic [DW-1:0] CMD_WMASK  = 16'h03BF;
  localparam logic [DW-1:0] CMD_RESET  = 16'h0094;
  localparam logic [DW-1:0] SRST_DROP  = 16'h0303;
  localparam logic [DW-1:0] SRST_SET   = 16'h0084;
  localparam logic [DW-1:0] MASK_WMASK = 16'h7FFF;
  localparam logic [DW-1:0] TXC_WMASK  = 16'hF000;
  localparam logic [DW-1:0] RXC_WMASK  = 16'hFFE0;
  localparam logic [DW-1:0] CFG_WMASK  = 16'hBFFF;
  localparam logic [DW-1:0] CFG2_WMASK = 16'hF017;
  localparam logic [DW-1:0] PTR_WMASK  = 16'hFFFE;
  localparam logic [DW-1:0] EOB_RESET  = 16'h02F8;
endpackage

// File: rtl/netctl_cmd.sv
module netctl_cmd
  import netctl_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_we,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] cmd_q,
  output logic [DW-1:0] pulse_q
);
  logic [DW-1:0] acc, clr, nxt, pls;

  always_comb begin
    acc = wdata & CMD_WMASK;
    clr = '0;
    for (int p = 0; p < NPAIR; p++) begin
      if (acc[PAIR_A[p]]) clr[PAIR_B[p]] = 1'b1;
      if (acc[PAIR_B[p]]) clr[PAIR_A[p]] = 1'b1;
    end
    nxt = (cmd_q | acc) & ~clr;
    pls = acc;
    if (acc[CB_SRST]) begin
      nxt = (nxt & ~SRST_DROP) | SRST_SET;
      pls = acc & ~SRST_DROP;
    end
    if (cmd_q[CB_SRST] && !wdata[CB_SRST]) begin
      nxt = cmd_q;
      nxt[CB_SRST] = 1'b0;
      pls = '0;
    end
    if (!cmd_we) pls = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q   <= CMD_RESET;
      pulse_q <= '0;
    end else begin
      pulse_q <= pls;
      if (cmd_we) cmd_q <= nxt;
    end
  end
endmodule

// File: rtl/netctl_irq.sv
module netctl_irq
  import netctl_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          stat_we,
  input  logic          mask_we,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] evt_set,
  output logic [DW-1:0] stat_q,
  output logic [DW-1:0] mask_q,
  output logic          irq_q
);
  logic [DW-1:0] stat_d, mask_d;

  always_comb begin
    stat_d = (stat_we ? (stat_q & ~wdata) : stat_q) | evt_set;
    mask_d = mask_we ? (wdata & MASK_WMASK) : mask_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= '0;
      mask_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      stat_q <= stat_d;
      mask_q <= mask_d;
      irq_q  <= |(stat_d & mask_d);
    end
  end
endmodule

// File: rtl/netctl_store.sv
module netctl_store
  import netctl_pkg::*;
#(
  parameter int NREGS = REG_COUNT,
  parameter int AW    = $clog2(NREGS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          in_reset,
  output logic [DW-1:0] rd_val,
  output logic [DW-1:0] cfg_q
);
  localparam logic [AW-1:0] AD_TXC  = AW'(A_TXC);
  localparam logic [AW-1:0] AD_RXC  = AW'(A_RXC);
  localparam logic [AW-1:0] AD_CFG  = AW'(A_CFG);
  localparam logic [AW-1:0] AD_CFG2 = AW'(A_CFG2);
  localparam logic [AW-1:0] AD_EOB  = AW'(A_EOB);

  logic [DW-1:0] mem [NREGS];
  logic [DW-1:0] mem_q, spec_q, txc_q, rxc_q, cfg2_q, eob_q, wval;
  logic          spec_sel_q;
  logic [NREGS-1:0] is_ptr, is_tal, is_mem;

  for (genvar g = 0; g < NREGS; g++) begin : g_kind
    assign is_ptr[g] = (g >= PTR_BASE) && (g < PTR_BASE + PTR_CNT);
    assign is_tal[g] = (g >= TAL_BASE) && (g < TAL_BASE + TAL_CNT);
    assign is_mem[g] = (g >= GEN_BASE);
  end

  always_comb begin
    if (is_tal[addr])      wval = ~wdata;
    else if (is_ptr[addr]) wval = wdata & PTR_WMASK;
    else                   wval = wdata;
  end

  // plain storage, no reset so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (we && is_mem[addr]) mem[addr] <= wval;
    if (rd_en) mem_q <= mem[addr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      txc_q      <= '0;
      rxc_q      <= '0;
      cfg_q      <= '0;
      cfg2_q     <= '0;
      eob_q      <= EOB_RESET;
      spec_q     <= '0;
      spec_sel_q <= 1'b1;
    end else begin
      if (we) begin
        case (addr)
          AD_TXC:  txc_q <= wdata & TXC_WMASK;
          AD_RXC:  rxc_q <= wdata & RXC_WMASK;
          AD_CFG:  if (in_reset) cfg_q <= wdata & CFG_WMASK;
          AD_CFG2: if (in_reset) cfg2_q <= wdata & CFG2_WMASK;
          AD_EOB:  eob_q <= wdata;
          default: ;
        endcase
      end
      if (rd_en) begin
        spec_sel_q <= !is_mem[addr];
        case (addr)
          AD_TXC:  spec_q <= txc_q;
          AD_RXC:  spec_q <= rxc_q;
          AD_CFG:  spec_q <= cfg_q;
          AD_CFG2: spec_q <= cfg2_q;
          AD_EOB:  spec_q <= eob_q;
          default: spec_q <= '0;
        endcase
      end
    end
  end

  assign rd_val = spec_sel_q ? spec_q : mem_q;
endmodule

// File: rtl/netctl_regs.sv
module netctl_regs
  import netctl_pkg::*;
#(
  parameter int NREGS = REG_COUNT,
  parameter int AW    = $clog2(NREGS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] evt_set,
  output logic [DW-1:0] rdata,
  output logic          irq,
  output logic [DW-1:0] cmd_pulse
);
  localparam logic [AW-1:0] AD_CMD  = AW'(A_CMD);
  localparam logic [AW-1:0] AD_STAT = AW'(A_STAT);
  localparam logic [AW-1:0] AD_MASK = AW'(A_MASK);

  logic [DW-1:0] cmd_q, stat_q, mask_q, cfg_q, st_rd, hold_q;
  logic          hold_sel_q;

  netctl_cmd u_cmd (
    .clk     (clk),
    .rst     (rst),
    .cmd_we  (wr_en && addr == AD_CMD),
    .wdata   (wdata),
    .cmd_q   (cmd_q),
    .pulse_q (cmd_pulse)
  );

  netctl_irq u_irq (
    .clk     (clk),
    .rst     (rst),
    .stat_we (wr_en && addr == AD_STAT),
    .mask_we (wr_en && addr == AD_MASK),
    .wdata   (wdata),
    .evt_set (evt_set),
    .stat_q  (stat_q),
    .mask_q  (mask_q),
    .irq_q   (irq)
  );

  netctl_store #(.NREGS(NREGS), .AW(AW)) u_store (
    .clk      (clk),
    .rst      (rst),
    .we       (wr_en),
    .rd_en    (rd_en),
    .addr     (addr),
    .wdata    (wdata),
    .in_reset (cmd_q[CB_SRST]),
    .rd_val   (st_rd),
    .cfg_q    (cfg_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q     <= '0;
      hold_sel_q <= 1'b0;
    end else if (rd_en) begin
      hold_sel_q <= (addr == AD_CMD) || (addr == AD_STAT) || (addr == AD_MASK);
      case (addr)
        AD_CMD:  hold_q <= cmd_q;
        AD_STAT: hold_q <= stat_q;
        AD_MASK: hold_q <= mask_q;
        default: hold_q <= '0;
      endcase
    end
  end

  assign rdata = hold_sel_q ? hold_q : st_rd;
endmodule

// File: rtl/netctl_regs_chk.sv
module netctl_regs_chk
  import netctl_pkg::*;
#(
  parameter int AW = 6
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_en,
  input logic [AW-1:0] addr,
  input logic [DW-1:0] wdata,
  input logic [DW-1:0] evt_set,
  input logic          irq,
  input logic [DW-1:0] cmd_pulse,
  input logic [DW-1:0] cmd_q,
  input logic [DW-1:0] stat_q,
  input logic [DW-1:0] mask_q,
  input logic [DW-1:0] cfg_q
);
  localparam logic [AW-1:0] AD_CMD  = AW'(A_CMD);
  localparam logic [AW-1:0] AD_STAT = AW'(A_STAT);
  localparam logic [AW-1:0] AD_CFG  = AW'(A_CFG);

  // R2
  irq_level_chk: assert property (@(posedge clk) disable iff (rst)
    irq == (|(mask_q & stat_q)));

  // R3
  stat_w1c_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == AD_STAT && evt_set == '0) |=>
      stat_q == ($past(stat_q) & ~$past(wdata)));

  // R4
  evt_kept_chk: assert property (@(posedge clk) disable iff (rst)
    (|evt_set) |=> ((stat_q & $past(evt_set)) == $past(evt_set)));

  // R6
  cfg_locked_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == AD_CFG && !cmd_q[CB_SRST]) |=> $stable(cfg_q));

  // R7
  cmd_legal_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_q & ~CMD_WMASK) == '0);

  // R8
  release_only_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == AD_CMD && cmd_q[CB_SRST] && !wdata[CB_SRST]) |=>
      (!cmd_q[CB_SRST] && cmd_pulse == '0));

  // R9
  rx_cancel_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == AD_CMD && wdata[CB_RXON] && !wdata[CB_SRST] && !cmd_q[CB_SRST])
      |=> !cmd_q[CB_RXOFF]);
endmodule

bind netctl_regs netctl_regs_chk #(.AW(AW)) u_chk (.*);

// File: tb/netctl_regs_bench.sv
`timescale 1ns/1ps
module netctl_regs_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [5:0]  addr = '0;
  logic [15:0] wdata = '0, evt_set = '0;
  wire  [15:0] rdata, cmd_pulse;
  wire         irq;

  always #2 clk = ~clk;

  netctl_regs u_netctl_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .evt_set(evt_set), .rdata(rdata), .irq(irq),
    .cmd_pulse(cmd_pulse)
  );

  int    checks = 0;
  int    fails  = 0;
  string cur_req = "R1";
  bit    done = 0;

  // behavioural reference state
  logic [15:0] m_cmd, m_stat, m_mask, m_txc, m_rxc, m_cfg, m_cfg2, m_eob;
  logic [15:0] m_rd = '0, m_pls = '0, v, n_stat;
  logic        m_irq = 1'b0;
  logic [15:0] m_mem [0:63];

  always @(posedge clk) begin
    if (rst) begin
      m_cmd = 16'h0094; m_stat = 0; m_mask = 0; m_txc = 0; m_rxc = 0;
      m_cfg = 0; m_cfg2 = 0; m_eob = 16'h02F8; m_rd = 0; m_irq = 0; m_pls = 0;
    end else begin
      if (rd_en) begin
        case (addr)
          0: m_rd = m_cmd;   1: m_rd = m_stat;  2: m_rd = m_mask;
          3: m_rd = m_txc;   4: m_rd = m_rxc;   5: m_rd = m_cfg;
          6: m_rd = m_cfg2;  7: m_rd = m_eob;
          default: m_rd = m_mem[addr];
        endcase
      end
      m_pls = 0;
      n_stat = m_stat;
      if (wr_en) begin
        case (addr)
          0: begin
            if (m_cmd[7] && !wdata[7]) m_cmd[7] = 1'b0;
            else begin
              v = wdata & 16'h03BF;
              m_cmd = m_cmd | v;
              if (v[2]) m_cmd[3] = 1'b0;
              if (v[3]) m_cmd[2] = 1'b0;
              if (v[4]) m_cmd[5] = 1'b0;
              if (v[5]) m_cmd[4] = 1'b0;
              if (v[7]) begin
                m_cmd = (m_cmd & ~16'h0303) | 16'h0084;
                m_pls = v & ~16'h0303;
              end else m_pls = v;
            end
          end
          1: n_stat = m_stat & ~wdata;
          2: m_mask = wdata & 16'h7FFF;
          3: m_txc = wdata & 16'hF000;
          4: m_rxc = wdata & 16'hFFE0;
          5: if (m_cmd[7]) m_cfg = wdata & 16'hBFFF;
          6: if (m_cmd[7]) m_cfg2 = wdata & 16'hF017;
          7: m_eob = wdata;
          default: begin
            if (addr >= 12 && addr <= 14) m_mem[addr] = ~wdata;
            else if (addr >= 8 && addr <= 11) m_mem[addr] = wdata & 16'hFFFE;
            else m_mem[addr] = wdata;
          end
        endcase
      end
      m_stat = n_stat | evt_set;
      m_irq = |(m_mask & m_stat);
    end
  end

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      checks++;
      if (rdata !== m_rd || irq !== m_irq || cmd_pulse !== m_pls) begin
        fails++;
        $display("FAIL %s cycle compare: actual rdata=%h irq=%b pulse=%h expected rdata=%h irq=%b pulse=%h",
                 cur_req, rdata, irq, cmd_pulse, m_rd, m_irq, m_pls);
      end
    end
  end

  task automatic op(input logic we, input logic re, input logic [5:0] a,
                    input logic [15:0] d, input logic [15:0] e);
    wr_en = we; rd_en = re; addr = a; wdata = d; evt_set = e;
    @(negedge clk);
    wr_en = 0; rd_en = 0; evt_set = 0;
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    op(1'b1, 1'b0, a, d, 16'h0);
  endtask

  task automatic chk16(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rdc(input logic [5:0] a, input logic [15:0] exp, input string req);
    op(1'b0, 1'b1, a, 16'h0, 16'h0);
    chk16(req, rdata, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset values
    cur_req = "R1";
    rdc(0, 16'h0094, "R1"); rdc(1, 16'h0000, "R1"); rdc(2, 16'h0000, "R1");
    rdc(3, 16'h0000, "R1"); rdc(4, 16'h0000, "R1"); rdc(5, 16'h0000, "R1");
    rdc(6, 16'h0000, "R1"); rdc(7, 16'h02F8, "R1");
    chk16("R1", {15'h0, irq}, 16'h0);
    // R6 configuration while in reset
    cur_req = "R6";
    wr(5, 16'hFFFF); rdc(5, 16'hBFFF, "R6");
    wr(6, 16'hFFFF); rdc(6, 16'hF017, "R6");
    // R8 release without applying receiver-on
    cur_req = "R8";
    wr(0, 16'h0008); chk16("R8", cmd_pulse, 16'h0000);
    rdc(0, 16'h0014, "R8");
    cur_req = "R6";
    wr(5, 16'h1234); rdc(5, 16'hBFFF, "R6");
    // R7 / R9 command accumulation and cancellation
    cur_req = "R9";
    wr(0, 16'h0008); chk16("R7", cmd_pulse, 16'h0008);
    rdc(0, 16'h0018, "R9");
    wr(0, 16'h0020); rdc(0, 16'h0028, "R9");
    wr(0, 16'h000C); chk16("R7", cmd_pulse, 16'h000C);
    rdc(0, 16'h0020, "R9");
    cur_req = "R7";
    wr(0, 16'h0303); chk16("R7", cmd_pulse, 16'h0303);
    rdc(0, 16'h0323, "R7");
    wr(0, 16'hFC40); chk16("R7", cmd_pulse, 16'h0000);
    rdc(0, 16'h0323, "R7");
    // R10 software reset
    cur_req = "R10";
    wr(0, 16'h0088); chk16("R10", cmd_pulse, 16'h0088);
    rdc(0, 16'h00AC, "R10");
    wr(0, 16'h0280); chk16("R10", cmd_pulse, 16'h0080);
    rdc(0, 16'h00AC, "R10");
    cur_req = "R8";
    wr(0, 16'h0000); chk16("R8", cmd_pulse, 16'h0000);
    rdc(0, 16'h002C, "R8");
    // R5 field masks
    cur_req = "R5";
    wr(2, 16'hFFFF); rdc(2, 16'h7FFF, "R5");
    wr(3, 16'hFFFF); rdc(3, 16'hF000, "R5");
    wr(4, 16'hFFFF); rdc(4, 16'hFFE0, "R5");
    // R2 / R3 / R4 status and interrupt
    cur_req = "R4";
    op(1'b0, 1'b0, 0, 16'h0, 16'h0081);
    chk16("R4", {15'h0, irq}, 16'h1);
    rdc(1, 16'h0081, "R4");
    cur_req = "R3";
    wr(1, 16'h0001); rdc(1, 16'h0080, "R3");
    chk16("R3", {15'h0, irq}, 16'h1);
    cur_req = "R2";
    wr(2, 16'h0000); chk16("R2", {15'h0, irq}, 16'h0);
    wr(2, 16'h0080); chk16("R2", {15'h0, irq}, 16'h1);
    cur_req = "R4";
    op(1'b1, 1'b0, 1, 16'hFFFF, 16'h0080);
    rdc(1, 16'h0080, "R4");
    cur_req = "R3";
    wr(1, 16'h0080); chk16("R3", {15'h0, irq}, 16'h0);
    rdc(1, 16'h0000, "R3");
    cur_req = "R2";
    wr(2, 16'hFFFF);
    op(1'b0, 1'b0, 0, 16'h0, 16'h8000);
    chk16("R2", {15'h0, irq}, 16'h0);
    rdc(1, 16'h8000, "R2");
    wr(1, 16'h8000);
    // R11 write transforms
    cur_req = "R11";
    wr(8, 16'h1235);  rdc(8, 16'h1234, "R11");
    wr(11, 16'hFFFF); rdc(11, 16'hFFFE, "R11");
    wr(12, 16'h1234); rdc(12, 16'hEDCB, "R11");
    wr(14, 16'h0000); rdc(14, 16'hFFFF, "R11");
    wr(40, 16'hA5A5); rdc(40, 16'hA5A5, "R11");
    wr(7, 16'h1234);  rdc(7, 16'h1234, "R11");
    // R12 read timing
    cur_req = "R12";
    op(1'b1, 1'b1, 40, 16'h0F0F, 16'h0);
    chk16("R12", rdata, 16'hA5A5);
    @(negedge clk); @(negedge clk);
    chk16("R12", rdata, 16'hA5A5);
    rdc(40, 16'h0F0F, "R12");
    done = 1;
    $display("Result: errors=%0d of %0d checks", fails, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL R12 watchdog: actual=hung expected=complete");
      $display("Result: errors=%0d of %0d checks", fails, checks);
      $finish;
    end
  end
endmodule